// File: doc/BRIEF.md
# Radix-4 Integer Divider with Leading-Chunk Skip

This block is a multi-cycle divide and remainder unit for an integer execute lane. It is given one operation at a time: a start pulse together with a dividend, a divisor and a two-bit operation code. It returns one result word with a single-cycle done strobe. It handles signed and unsigned quotients and remainders. Signed work is done on magnitudes, and the signs are restored at the end.

Each iteration cycle resolves two quotient bits. At each step the shifted partial remainder is compared with one, two and three times the divisor. Before iterating, the unit looks at the dividend magnitude in chunks of XLEN/4 bits, starting from the top. It drops every leading chunk that is all zero, so small dividends finish in fewer cycles. Division by zero and signed overflow bypass the iteration entirely. The operand state is held inside the block from the accepted start until the done strobe.

Top module: `div4_skip_unit`

## Requirements
- R1: With op_i = 2'b01 (unsigned quotient), the result is floor(dividend / divisor) for a nonzero divisor, with both operands taken as unsigned.
- R2: With op_i = 2'b11 (unsigned remainder), the result is dividend mod divisor for a nonzero divisor, with both operands taken as unsigned.
- R3: With op_i = 2'b00 (signed quotient), operands are two's complement and the quotient truncates toward zero. It is negative exactly when the operand signs differ and the quotient is nonzero.
- R4: With op_i = 2'b10 (signed remainder), the remainder takes the sign of the dividend and has a smaller magnitude than the divisor.
- R5: A zero divisor gives a quotient of all ones and a remainder equal to the dividend, for both signed and unsigned codes.
- R6: For a signed code, the most negative dividend divided by all ones (-1) gives that dividend as quotient and zero as remainder.
- R7: Let G = XLEN/4 and let k (0..4) be the number of leading all-zero G-bit chunks of the dividend magnitude. The magnitude is the absolute value for signed codes and the raw value for unsigned codes. done_o is high in the cycle that follows the (N+1)-th rising edge after the accepting edge counts from 1, where N = (XLEN - k*G)/2. Put simply, the measured latency is N+1 clocks. Cases covered by R5 and R6 take 1 clock.
- R8: busy_o rises on the edge that accepts a start and stays high through the done cycle. done_o is high for exactly one cycle per accepted operation.
- R9: A start_i pulse while busy_o is high is ignored. The operation in flight keeps its operands and code, and no extra done strobe appears.
- R10: During and after reset, busy_o and done_o are low. result_o is zero in every cycle where done_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted when busy_o is low |
| op_i | input | 2 | Operation: bit 1 selects remainder, bit 0 selects unsigned |
| dividend_i | input | XLEN | Dividend |
| divisor_i | input | XLEN | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid strobe, one cycle |
| result_o | output | XLEN | Quotient or remainder, zero when done_o is low |

## Verification
The hardest behaviour to reach from the ports is the interaction between chunk skipping and sign handling. A negative signed dividend with a small magnitude must skip on its absolute value and not on its raw bits. Such an operand looks full-width at the pins yet finishes in a handful of cycles. The stimulus therefore pairs negative dividends near -1 with divisors of both signs, and sweeps dividends whose highest nonzero chunk moves through every position, including zero. The latency of each operation is checked against the chunk count worked out in the bench. A long operation is also pelted with start pulses that carry different operands and codes, to show that the one in flight holds its state.

// File: rtl/div4_pkg.sv
package div4_pkg;

   // bit 1: remainder result, bit 0: unsigned operands
   typedef enum logic [1:0] {
      OP_DIV  = 2'b00,
      OP_DIVU = 2'b01,
      OP_REM  = 2'b10,
      OP_REMU = 2'b11
   } div_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_FIN  = 2'b10
   } div_state_e;

endpackage

// File: rtl/div4_prep.sv
module div4_prep #(
   parameter int XLEN    = 32,
   parameter bit SKIP_EN = 1'b1,
   localparam int GRAN   = XLEN / 4,
   localparam int HALF   = XLEN / 2,
   localparam int CNTW   = $clog2(HALF + 1)
) (
   input  logic [1:0]      op_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic [XLEN-1:0] a_align_o,
   output logic [XLEN-1:0] b_mag_o,
   output logic            neg_q_o,
   output logic            neg_r_o,
   output logic            div_zero_o,
   output logic            ovf_o,
   output logic [CNTW-1:0] steps_o
);

   logic            is_signed;
   logic            a_neg, b_neg;
   logic [XLEN-1:0] a_mag;
   logic [2:0]      skip_chunks;

   assign is_signed = ~op_i[0];
   assign a_neg     = is_signed & a_i[XLEN-1];
   assign b_neg     = is_signed & b_i[XLEN-1];
   assign a_mag     = a_neg ? (~a_i + 1'b1) : a_i;
   assign b_mag_o   = b_neg ? (~b_i + 1'b1) : b_i;

   assign neg_q_o    = a_neg ^ b_neg;
   assign neg_r_o    = a_neg;
   assign div_zero_o = (b_i == '0);
   assign ovf_o      = is_signed && (a_i == {1'b1, {(XLEN-1){1'b0}}}) && (b_i == '1);

   generate
      if (SKIP_EN) begin : g_skip
         always_comb begin
            logic lead;
            skip_chunks = '0;
            lead        = 1'b1;
            for (int i = 3; i >= 0; i--) begin
               if (lead && (a_mag[i*GRAN +: GRAN] == '0)) skip_chunks = skip_chunks + 3'd1;
               else lead = 1'b0;
            end
         end
      end else begin : g_noskip
         assign skip_chunks = '0;
      end
   endgenerate

   assign a_align_o = (skip_chunks == 3'd4) ? '0 : (a_mag << (int'(skip_chunks) * GRAN));
   assign steps_o   = CNTW'(HALF) - CNTW'(skip_chunks) * CNTW'(GRAN / 2);

endmodule

// File: rtl/div4_step.sv
module div4_step #(
   parameter int XLEN = 32,
   localparam int W   = XLEN + 2
) (
   input  logic [XLEN-1:0] rem_i,
   input  logic [1:0]      pair_i,
   input  logic [XLEN-1:0] dvs_i,
   output logic [1:0]      digit_o,
   output logic [XLEN-1:0] rem_o
);

   logic [W-1:0] r4;
   logic [W-1:0] mult [1:3];
   logic [3:1]   ge;

   assign r4 = {rem_i, pair_i};

   generate
      for (genvar m = 1; m <= 3; m++) begin : g_mult
         assign mult[m] = W'(dvs_i) * W'(m);
         assign ge[m]   = (r4 >= mult[m]);
      end
   endgenerate

   always_comb begin
      if (ge[3]) begin
         digit_o = 2'd3;
         rem_o   = r4[XLEN-1:0] - mult[3][XLEN-1:0];
      end else if (ge[2]) begin
         digit_o = 2'd2;
         rem_o   = r4[XLEN-1:0] - mult[2][XLEN-1:0];
      end else if (ge[1]) begin
         digit_o = 2'd1;
         rem_o   = r4[XLEN-1:0] - mult[1][XLEN-1:0];
      end else begin
         digit_o = 2'd0;
         rem_o   = r4[XLEN-1:0];
      end
   end

endmodule

// File: rtl/div4_fix.sv
module div4_fix #(
   parameter int XLEN = 32
) (
   input  logic            valid_i,
   input  logic            is_rem_i,
   input  logic [XLEN-1:0] quot_i,
   input  logic [XLEN-1:0] rem_i,
   input  logic            neg_q_i,
   input  logic            neg_r_i,
   input  logic            div_zero_i,
   input  logic            ovf_i,
   input  logic [XLEN-1:0] a_raw_i,
   output logic [XLEN-1:0] result_o
);

   logic [XLEN-1:0] q_fix, r_fix, q_sel, r_sel;

   assign q_fix = neg_q_i ? (~quot_i + 1'b1) : quot_i;
   assign r_fix = neg_r_i ? (~rem_i + 1'b1) : rem_i;

   always_comb begin
      if (div_zero_i) begin
         q_sel = '1;
         r_sel = a_raw_i;
      end else if (ovf_i) begin
         q_sel = a_raw_i;
         r_sel = '0;
      end else begin
         q_sel = q_fix;
         r_sel = r_fix;
      end
   end

   assign result_o = !valid_i ? '0 : (is_rem_i ? r_sel : q_sel);

endmodule

// File: rtl/div4_skip_unit.sv
module div4_skip_unit
   import div4_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter bit SKIP_EN = 1'b1,
   localparam int HALF   = XLEN / 2,
   localparam int CNTW   = $clog2(HALF + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [1:0]      op_i,
   input  logic [XLEN-1:0] dividend_i,
   input  logic [XLEN-1:0] divisor_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [XLEN-1:0] result_o
);

   generate
      if ((XLEN % 8) != 0 || XLEN < 8) begin : g_bad_xlen
         $error("div4_skip_unit: XLEN must be a multiple of 8");
      end
   endgenerate

   div_state_e      state_q;
   logic [XLEN-1:0] dd_q, rem_q, quot_q, dvs_q, a_raw_q;
   logic [CNTW-1:0] cnt_q;
   logic            is_rem_q, neg_q_q, neg_r_q, dz_q, ovf_q;

   logic [XLEN-1:0] p_align, p_bmag;
   logic            p_negq, p_negr, p_dz, p_ovf;
   logic [CNTW-1:0] p_steps;
   logic [1:0]      s_digit;
   logic [XLEN-1:0] s_rem;
   logic            accept;

   assign accept = start_i && (state_q == ST_IDLE);

   div4_prep #(.XLEN(XLEN), .SKIP_EN(SKIP_EN)) i_prep (
      .op_i       (op_i),
      .a_i        (dividend_i),
      .b_i        (divisor_i),
      .a_align_o  (p_align),
      .b_mag_o    (p_bmag),
      .neg_q_o    (p_negq),
      .neg_r_o    (p_negr),
      .div_zero_o (p_dz),
      .ovf_o      (p_ovf),
      .steps_o    (p_steps)
   );

   div4_step #(.XLEN(XLEN)) i_step (
      .rem_i   (rem_q),
      .pair_i  (dd_q[XLEN-1:XLEN-2]),
      .dvs_i   (dvs_q),
      .digit_o (s_digit),
      .rem_o   (s_rem)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         dd_q     <= '0;
         rem_q    <= '0;
         quot_q   <= '0;
         dvs_q    <= '0;
         a_raw_q  <= '0;
         cnt_q    <= '0;
         is_rem_q <= 1'b0;
         neg_q_q  <= 1'b0;
         neg_r_q  <= 1'b0;
         dz_q     <= 1'b0;
         ovf_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  dd_q     <= p_align;
                  rem_q    <= '0;
                  quot_q   <= '0;
                  dvs_q    <= p_bmag;
                  a_raw_q  <= dividend_i;
                  cnt_q    <= p_steps;
                  is_rem_q <= op_i[1];
                  neg_q_q  <= p_negq;
                  neg_r_q  <= p_negr;
                  dz_q     <= p_dz;
                  ovf_q    <= p_ovf;
                  state_q  <= (p_dz || p_ovf || p_steps == '0) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               dd_q   <= dd_q << 2;
               rem_q  <= s_rem;
               quot_q <= {quot_q[XLEN-3:0], s_digit};
               cnt_q  <= cnt_q - 1'b1;
               if (cnt_q == CNTW'(1)) state_q <= ST_FIN;
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_FIN);

   div4_fix #(.XLEN(XLEN)) i_fix (
      .valid_i    (done_o),
      .is_rem_i   (is_rem_q),
      .quot_i     (quot_q),
      .rem_i      (rem_q),
      .neg_q_i    (neg_q_q),
      .neg_r_i    (neg_r_q),
      .div_zero_i (dz_q),
      .ovf_i      (ovf_q),
      .a_raw_i    (a_raw_q),
      .result_o   (result_o)
   );

   // Each radix-4 step must leave a partial remainder below the divisor (R1, R2)
   p_rem_below_dvs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |-> (s_rem < dvs_q));

   // Iteration counter walks down one digit pair per cycle (R7)
   p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && cnt_q != CNTW'(1)) |=>
         (state_q == ST_RUN && cnt_q == $past(cnt_q) - 1'b1));

   // Last digit pair leads straight to the done cycle (R7)
   p_last_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && cnt_q == CNTW'(1)) |=> done_o);

   // Accepted start raises busy (R8)
   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // Done is a single-cycle strobe (R8)
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // Operand state is frozen while an operation is in flight (R9)
   p_hold_operands_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> ($stable(dvs_q) && $stable(a_raw_q) && $stable(is_rem_q)));

   // Zero divisor result (R5)
   p_div_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && dz_q) |-> (result_o == (is_rem_q ? a_raw_q : {XLEN{1'b1}})));

   // Signed overflow result (R6)
   p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ovf_q && !dz_q) |-> (result_o == (is_rem_q ? '0 : a_raw_q)));

endmodule

// File: tb/test_div4_skip_unit.sv
module test_div4_skip_unit;

   localparam int XLEN = 32;

   typedef struct {
      logic [XLEN-1:0] res;
      int              lat;
      int              t0;
      string           tag;
   } sb_item_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [1:0]      op_i = 2'b00;
   logic [XLEN-1:0] dividend_i = '0;
   logic [XLEN-1:0] divisor_i = '0;
   logic            busy_o, done_o;
   logic [XLEN-1:0] result_o;

   int       n_checks = 0;
   int       n_fail = 0;
   int       cyc = 0;
   bit       finished = 1'b0;
   bit       prev_done = 1'b0;
   sb_item_t sb[$];
   logic [31:0] rng = 32'h1357_9BDF;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   div4_skip_unit #(.XLEN(XLEN)) i_div4_skip_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .dividend_i(dividend_i), .divisor_i(divisor_i),
      .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
   );

   function automatic logic [XLEN-1:0] exp_res(logic [1:0] op, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
      if (b == '0) return op[1] ? a : '1;
      if (!op[0] && a == 32'h8000_0000 && b == '1) return op[1] ? '0 : a;
      if (op[0]) return op[1] ? (a % b) : (a / b);
      return op[1] ? XLEN'($signed(a) % $signed(b)) : XLEN'($signed(a) / $signed(b));
   endfunction

   function automatic int exp_lat(logic [1:0] op, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
      logic [XLEN-1:0] m;
      int k;
      bit lead;
      if (b == '0) return 1;
      if (!op[0] && a == 32'h8000_0000 && b == '1) return 1;
      m = (!op[0] && a[XLEN-1]) ? (~a + 1'b1) : a;
      k = 0;
      lead = 1'b1;
      for (int i = 3; i >= 0; i--) begin
         if (lead && m[i*8 +: 8] == 8'h00) k++;
         else lead = 1'b0;
      end
      return 1 + (XLEN - 8 * k) / 2;
   endfunction

   task automatic check(bit ok, string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic issue(logic [1:0] op, logic [XLEN-1:0] a, logic [XLEN-1:0] b, string tag);
      sb_item_t it;
      while (busy_o) @(negedge clk);
      op_i = op;
      dividend_i = a;
      divisor_i = b;
      start_i = 1'b1;
      it.res = exp_res(op, a, b);
      it.lat = exp_lat(op, a, b);
      it.t0  = cyc;
      it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // Monitor: pops scoreboard on every done strobe
   always @(negedge clk) begin
      if (rst_n) begin
         if (done_o) begin
            if (sb.size() == 0) begin
               check(1'b0, "R9", "done with no pending operation", result_o, '0);
            end else begin
               sb_item_t it;
               it = sb.pop_front();
               check(result_o === it.res, it.tag, "result", result_o, it.res);
               check((cyc - it.t0) == it.lat, "R7", "latency", XLEN'(cyc - it.t0), XLEN'(it.lat));
               check(busy_o === 1'b1, "R8", "busy during done", {31'b0, busy_o}, 32'd1);
            end
            if (prev_done) check(1'b0, "R8", "done longer than one cycle", 32'd1, 32'd0);
         end
         prev_done = done_o;
      end
   end

   initial begin
      repeat (1000000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check(busy_o === 1'b0, "R10", "busy in reset", {31'b0, busy_o}, 32'd0);
      check(done_o === 1'b0, "R10", "done in reset", {31'b0, done_o}, 32'd0);
      check(result_o === '0, "R10", "result in reset", result_o, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy_o === 1'b0, "R10", "busy after reset", {31'b0, busy_o}, 32'd0);

      // R1 unsigned quotient
      issue(2'b01, 32'd100, 32'd7, "R1");
      issue(2'b01, 32'hFFFF_FFFF, 32'd1, "R1");
      issue(2'b01, 32'h0123_4567, 32'h10, "R1");
      issue(2'b01, 32'h8000_0000, 32'hFFFF_FFFF, "R1");
      // R2 unsigned remainder
      issue(2'b11, 32'd100, 32'd7, "R2");
      issue(2'b11, 32'hFFFF_FFFF, 32'h0001_0000, "R2");
      issue(2'b11, 32'd5, 32'd9, "R2");
      // R3 signed quotient
      issue(2'b00, 32'hFFFF_FFF9, 32'd2, "R3");
      issue(2'b00, 32'd7, 32'hFFFF_FFFE, "R3");
      issue(2'b00, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R3");
      issue(2'b00, 32'h8000_0000, 32'd3, "R3");
      // R4 signed remainder
      issue(2'b10, 32'hFFFF_FFF9, 32'd2, "R4");
      issue(2'b10, 32'd7, 32'hFFFF_FFFE, "R4");
      issue(2'b10, 32'h8000_0001, 32'h7FFF_FFFF, "R4");
      // R5 zero divisor
      issue(2'b01, 32'd5, 32'd0, "R5");
      issue(2'b10, 32'hFFFF_FFFB, 32'd0, "R5");
      issue(2'b00, 32'h1234, 32'd0, "R5");
      issue(2'b11, 32'h0, 32'd0, "R5");
      // R6 signed overflow
      issue(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
      issue(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
      // R7 chunk skip positions, including negative small magnitudes
      issue(2'b01, 32'h0, 32'd3, "R7");
      issue(2'b01, 32'hFF, 32'd3, "R7");
      issue(2'b01, 32'h0000_FF00, 32'd3, "R7");
      issue(2'b01, 32'h00FF_0000, 32'd3, "R7");
      issue(2'b00, 32'hFFFF_FFFF, 32'd1, "R7");
      issue(2'b10, 32'hFFFF_FF01, 32'hFFFF_FFF0, "R7");
      issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7");

      // R9: start pulses during a long operation are ignored
      issue(2'b01, 32'hFFFF_FFFF, 32'd3, "R9");
      for (int i = 0; i < 4; i++) begin
         op_i = 2'b10;
         dividend_i = 32'h0000_0011 + i;
         divisor_i = 32'd0;
         start_i = 1'b1;
         @(negedge clk);
         check(busy_o === 1'b1, "R9", "busy while start ignored", {31'b0, busy_o}, 32'd1);
      end
      start_i = 1'b0;
      while (busy_o) @(negedge clk);
      repeat (5) @(negedge clk);
      check(done_o === 1'b0, "R9", "no extra done", {31'b0, done_o}, 32'd0);
      check(result_o === '0, "R10", "result quiet when idle", result_o, '0);

      // Mixed sweep across ops and chunk positions
      for (int i = 0; i < 80; i++) begin
         logic [XLEN-1:0] a, b;
         rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
         a = rng >> (8 * (i % 4));
         if ((i % 7) == 3) a = ~a;
         rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
         b = rng >> (4 * (i % 8));
         if ((i % 5) == 2) b = ~b;
         issue(2'(i % 4), a, b, (i % 4 == 0) ? "R3" : (i % 4 == 1) ? "R1" : (i % 4 == 2) ? "R4" : "R2");
      end

      while (busy_o || sb.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      summary();
   end

endmodule